// File: doc/BRIEF.md
# Sync-Pattern Serial Frame Deframer

This block rebuilds byte frames from a stream of serial bits whose timing has already been recovered upstream. Each incoming bit arrives as a value plus a one-cycle valid strobe, and any number of idle cycles may separate two bits. The block watches for a run of consecutive ones that marks the start of a frame. After that run it cuts the stream into fixed 9-bit words. The first bit of each word must be zero and is thrown away. The remaining eight bits form a data byte, received most significant bit first.

Each rebuilt byte is presented with a one-cycle valid strobe, its position within the frame, and a start-of-frame flag on the first byte. After the last byte of the frame, a frame-done pulse is given and the block goes back to hunting for the next sync run. A word whose leading bit is one breaks the frame: the block raises a frame-error pulse and goes back to hunting. No data word can contain nine ones in a row, so a run of nine ones starts a new frame from any state.

Top module: `sync_deframer`

## Requirements
- R1: While reset is asserted and after it is released, byte_vld, frame_sof, frame_done and frame_err are 0, and byte_data and byte_idx read 0. Reset also clears the count of ones seen, so ones received before reset never combine with ones received after it to form a sync.
- R2: Nine consecutive valid 1 bits form a sync, in any state and even in the middle of a frame. A longer run of ones keeps re-arming the sync. The first valid 0 after the run is the leading bit of byte 0. A 1 that completes such a run never raises frame_err.
- R3: After sync, every 9 valid bits form one word. The first bit of the word is dropped, and the next 8 bits form byte_data with the first of them as bit 7. byte_vld goes high for exactly one cycle, on the clock after the edge that accepts the word's ninth bit.
- R4: byte_idx counts the bytes of a frame from 0 to 18 in arrival order. frame_sof is high only together with byte_vld for byte 0.
- R5: frame_done pulses together with byte_vld for byte 18. After that, no byte is produced until a new sync has been received.
- R6: If a word's leading bit is 1 and that bit does not complete a sync run, frame_err pulses for one cycle on the next clock. No byte is produced for that word, and the block returns to hunting for sync.
- R7: Cycles with ser_vld low change nothing, whatever ser_bit holds in them.
- R8: A valid 0 clears the run of ones, so eight ones followed by a 0 do not form a sync.
- R9: frame_done and frame_err are never high in the same cycle, and all strobes fall in the cycle after they pulse unless a new bit causes them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_bit | input | 1 | Recovered serial bit value |
| ser_vld | input | 1 | One-cycle strobe marking ser_bit as a new bit |
| byte_data | output | 8 | Rebuilt data byte, first received bit in bit 7 |
| byte_vld | output | 1 | One-cycle strobe: byte_data, byte_idx and frame_sof are valid |
| byte_idx | output | 5 | Position of the byte within the frame, 0 to 18 |
| frame_sof | output | 1 | High with byte_vld for byte 0 |
| frame_done | output | 1 | High with byte_vld for the last byte of the frame |
| frame_err | output | 1 | One-cycle pulse when a word's leading bit is 1 |

## Verification
The assertions assume that ser_vld and ser_bit hold known values at every sampled edge once reset is released. They also assume that a bit counts once for each cycle in which ser_vld is high, so a bit held high for two cycles counts as two bits. The bench drives both inputs only on the falling clock edge and raises ser_vld for a single cycle per bit. Between bits it leaves gaps of zero to twenty idle cycles, and it toggles ser_bit while ser_vld is low. This keeps the stimulus inside those assumptions while it exercises the rule that idle cycles are ignored.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_DATA = 1'b1
  } sdf_state_e;

endpackage

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int RUN_LEN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic sync_hit
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] SAT = CW'(RUN_LEN);
  localparam logic [CW-1:0] ARM = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // a run at or beyond the threshold re-arms on every further one
  assign sync_hit = bit_vld & bit_in & (run_q >= ARM);

  always_comb begin
    run_d = run_q;
    if (!bit_in) begin
      run_d = '0;
    end else if (run_q != SAT) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_vld) begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [DATA_BITS-1:0] byte_next
);

  logic [DATA_BITS-2:0] sh_q;
  logic [DATA_BITS-2:0] sh_d;

  // the current bit lands in the LSB; earlier bits sit above it
  assign byte_next = {sh_q, bit_in};

  always_comb begin
    sh_d = byte_next[DATA_BITS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_d;
    end
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import sdf_pkg::*;
#(
  parameter int WORD_BITS   = 9,
  parameter int FRAME_BYTES = 19
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_vld,
  input  logic                           bit_in,
  input  logic                           sync_hit,
  output logic                           shift_en,
  output logic                           word_done,
  output logic                           frame_last,
  output logic                           lead_err,
  output logic [$clog2(FRAME_BYTES)-1:0] cur_idx
);

  localparam int PW = $clog2(WORD_BITS);
  localparam int IW = $clog2(FRAME_BYTES);
  localparam logic [PW-1:0] LAST_POS = PW'(WORD_BITS - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BYTES - 1);

  sdf_state_e    state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [IW-1:0] idx_q, idx_d;

  logic take;
  logic at_lead;
  logic at_tail;

  // sync has precedence over any word handling
  assign take       = bit_vld & ~sync_hit & (state_q == ST_DATA);
  assign at_lead    = (pos_q == '0);
  assign at_tail    = (pos_q == LAST_POS);
  assign shift_en   = take & ~at_lead;
  assign word_done  = take & at_tail;
  assign frame_last = word_done & (idx_q == LAST_IDX);
  assign lead_err   = take & at_lead & bit_in;
  assign cur_idx    = idx_q;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    idx_d   = idx_q;
    if (bit_vld) begin
      if (sync_hit) begin
        state_d = ST_DATA;
        pos_d   = '0;
        idx_d   = '0;
      end else if (state_q == ST_DATA) begin
        if (at_lead) begin
          if (bit_in) begin
            state_d = ST_HUNT;
            idx_d   = '0;
          end else begin
            pos_d = pos_q + 1'b1;
          end
        end else if (at_tail) begin
          pos_d = '0;
          if (idx_q == LAST_IDX) begin
            state_d = ST_HUNT;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      idx_q   <= '0;
    end else if (bit_vld) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/sync_deframer.sv
module sync_deframer #(
  parameter int SYNC_ONES   = 9,
  parameter int WORD_BITS   = 9,
  parameter int FRAME_BYTES = 19
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ser_bit,
  input  logic                           ser_vld,
  output logic [WORD_BITS-2:0]           byte_data,
  output logic                           byte_vld,
  output logic [$clog2(FRAME_BYTES)-1:0] byte_idx,
  output logic                           frame_sof,
  output logic                           frame_done,
  output logic                           frame_err
);

  localparam int DATA_BITS = WORD_BITS - 1;
  localparam int IW        = $clog2(FRAME_BYTES);

  logic                 sync_hit;
  logic                 shift_en;
  logic                 word_done;
  logic                 frame_last;
  logic                 lead_err;
  logic [IW-1:0]        cur_idx;
  logic [DATA_BITS-1:0] byte_next;

  ones_run_detector #(
    .RUN_LEN(SYNC_ONES)
  ) run_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (ser_vld),
    .bit_in  (ser_bit),
    .sync_hit(sync_hit)
  );

  frame_sequencer #(
    .WORD_BITS  (WORD_BITS),
    .FRAME_BYTES(FRAME_BYTES)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (ser_vld),
    .bit_in    (ser_bit),
    .sync_hit  (sync_hit),
    .shift_en  (shift_en),
    .word_done (word_done),
    .frame_last(frame_last),
    .lead_err  (lead_err),
    .cur_idx   (cur_idx)
  );

  word_shifter #(
    .DATA_BITS(DATA_BITS)
  ) shf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (ser_bit),
    .byte_next(byte_next)
  );

  // output stage: strobes every cycle, payload only on a finished word
  logic                 vld_d, sof_d, done_d, err_d;
  logic [DATA_BITS-1:0] data_q;
  logic [IW-1:0]        idx_q;
  logic                 vld_q, sof_q, done_q, err_q;

  always_comb begin
    vld_d  = word_done;
    sof_d  = word_done & (cur_idx == '0);
    done_d = frame_last;
    err_d  = lead_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      sof_q  <= sof_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
    end else if (word_done) begin
      data_q <= byte_next;
      idx_q  <= cur_idx;
    end
  end

  assign byte_data  = data_q;
  assign byte_vld   = vld_q;
  assign byte_idx   = idx_q;
  assign frame_sof  = sof_q;
  assign frame_done = done_q;
  assign frame_err  = err_q;

endmodule

// File: rtl/sync_deframer_chk.sv
module sync_deframer_chk #(
  parameter int SYNC_ONES   = 9,
  parameter int FRAME_BYTES = 19
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ser_bit,
  input logic                           ser_vld,
  input logic                           byte_vld,
  input logic [$clog2(FRAME_BYTES)-1:0] byte_idx,
  input logic                           frame_sof,
  input logic                           frame_done,
  input logic                           frame_err
);

  localparam int IW = $clog2(FRAME_BYTES);
  localparam int CW = $clog2(SYNC_ONES + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BYTES - 1);
  localparam logic [CW-1:0] ARM      = CW'(SYNC_ONES - 1);
  localparam logic [CW-1:0] SAT      = CW'(SYNC_ONES);

  // independent count of the current run of ones at the input
  logic [CW-1:0] seen_q;
  logic          sync_seen;

  assign sync_seen = ser_vld & ser_bit & (seen_q >= ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (ser_vld) begin
      if (!ser_bit)           seen_q <= '0;
      else if (seen_q != SAT) seen_q <= seen_q + 1'b1;
    end
  end

  assert_sync_beats_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_seen |=> !frame_err && !byte_vld);

  assert_vld_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  assert_sof_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> byte_vld && byte_idx == '0);

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_idx <= LAST_IDX);

  assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> byte_vld && byte_idx == LAST_IDX);

  assert_err_no_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !byte_vld);

  assert_strobe_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || frame_err) |-> $past(ser_vld));

  assert_done_err_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));

endmodule

bind sync_deframer sync_deframer_chk #(
  .SYNC_ONES  (SYNC_ONES),
  .FRAME_BYTES(FRAME_BYTES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_bit   (ser_bit),
  .ser_vld   (ser_vld),
  .byte_vld  (byte_vld),
  .byte_idx  (byte_idx),
  .frame_sof (frame_sof),
  .frame_done(frame_done),
  .frame_err (frame_err)
);

// File: tb/sync_deframer_tb_top.sv
module sync_deframer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 19;
  localparam logic [7:0] FRAME_TBL [NBYTES] = '{
    8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h7F, 8'hFE, 8'h3C, 8'hC3,
    8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h0F
  };

  logic       clk;
  logic       rst_n;
  logic       ser_bit;
  logic       ser_vld;
  logic [7:0] byte_data;
  logic       byte_vld;
  logic [4:0] byte_idx;
  logic       frame_sof;
  logic       frame_done;
  logic       frame_err;

  sync_deframer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_bit   (ser_bit),
    .ser_vld   (ser_vld),
    .byte_data (byte_data),
    .byte_vld  (byte_vld),
    .byte_idx  (byte_idx),
    .frame_sof (frame_sof),
    .frame_done(frame_done),
    .frame_err (frame_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;
  logic s_vld, s_sof, s_done, s_err;
  logic [7:0] s_byte;
  logic [4:0] s_idx;
  logic pulse_seen;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    ser_bit = b;
    ser_vld = 1'b1;
    @(negedge clk);
    s_vld  = byte_vld;
    s_sof  = frame_sof;
    s_done = frame_done;
    s_err  = frame_err;
    s_byte = byte_data;
    s_idx  = byte_idx;
    pulse_seen = pulse_seen | byte_vld | frame_err;
    ser_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_ones(input int n, input int gap);
    for (int k = 0; k < n; k++) send_bit(1'b1, gap);
  endtask

  task automatic send_word(input logic lead, input logic [7:0] v, input int gap);
    send_bit(lead, gap);
    for (int k = 7; k >= 0; k--) send_bit(v[k], gap);
  endtask

  task automatic chk_byte(input string req, input logic [7:0] v, input int idx);
    chk(req, "byte_vld", int'(s_vld), 1);
    chk(req, "byte_data", int'(s_byte), int'(v));
    chk(req, "byte_idx", int'(s_idx), idx);
    chk(req, "frame_sof", int'(s_sof), (idx == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ser_bit = 1'b0;
    ser_vld = 1'b0;
    pulse_seen = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "byte_vld", int'(byte_vld), 0);
    chk("R1", "frame_err|done|sof", int'({frame_err, frame_done, frame_sof}), 0);
    chk("R1", "byte_data", int'(byte_data), 0);
    chk("R1", "byte_idx", int'(byte_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R7: full frame from the table, with varied idle gaps
    send_ones(9, 0);
    for (int i = 0; i < NBYTES; i++) begin
      send_word(1'b0, FRAME_TBL[i], i % 3);
      chk_byte("R3_R4", FRAME_TBL[i], i);
      chk("R5", "frame_done", int'(s_done), (i == NBYTES - 1) ? 1 : 0);
      chk("R6", "frame_err", int'(s_err), 0);
    end
    @(negedge clk);
    chk("R9", "byte_vld after pulse", int'(byte_vld), 0);
    chk("R9", "frame_done after pulse", int'(frame_done), 0);

    // R5: hunting after the last byte, words give nothing
    pulse_seen = 1'b0;
    send_word(1'b0, 8'h42, 1);
    send_word(1'b0, 8'h00, 0);
    chk("R5", "pulse without sync", int'(pulse_seen), 0);

    // R2: a thirteen-one run still syncs, first 0 is the lead bit
    pulse_seen = 1'b0;
    send_ones(13, 1);
    chk("R2", "pulse during long run", int'(pulse_seen), 0);
    send_word(1'b0, 8'hC6, 0);
    chk_byte("R2", 8'hC6, 0);

    // R2: mid-frame resync, the 1 that makes nine ones is no error
    send_word(1'b0, 8'hFF, 0);
    chk_byte("R3", 8'hFF, 1);
    send_bit(1'b1, 0);
    chk("R2", "frame_err on sync-completing lead", int'(s_err), 0);
    send_word(1'b0, 8'h81, 0);
    chk_byte("R2", 8'h81, 0);

    // R6: lead bit 1 breaks the frame
    send_word(1'b0, 8'h00, 0);
    chk_byte("R6", 8'h00, 1);
    send_bit(1'b1, 0);
    chk("R6", "frame_err", int'(s_err), 1);
    chk("R6", "byte_vld with err", int'(s_vld), 0);
    @(negedge clk);
    chk("R9", "frame_err after pulse", int'(frame_err), 0);
    pulse_seen = 1'b0;
    for (int k = 0; k < 8; k++) send_bit(1'b0, 0);
    send_word(1'b0, 8'h3A, 0);
    chk("R6", "pulse while hunting", int'(pulse_seen), 0);

    // R8: eight ones then a zero are not a sync
    pulse_seen = 1'b0;
    send_ones(8, 0);
    send_word(1'b0, 8'h55, 0);
    chk("R8", "pulse after eight ones", int'(pulse_seen), 0);
    send_ones(9, 0);
    send_word(1'b0, 8'hAA, 0);
    chk_byte("R8", 8'hAA, 0);

    // R7: idle cycles with a toggling bit inside a word are ignored
    send_bit(1'b0, 0);
    send_bit(1'b1, 0);
    send_bit(1'b0, 0);
    send_bit(1'b1, 0);
    send_bit(1'b0, 0);
    for (int k = 0; k < 20; k++) begin
      ser_bit = ~ser_bit;
      @(negedge clk);
    end
    send_bit(1'b0, 0);
    send_bit(1'b0, 0);
    send_bit(1'b1, 0);
    send_bit(1'b1, 0);
    chk_byte("R7", 8'hA3, 1);

    // R1: reset mid-frame clears the run of ones
    send_word(1'b0, 8'h00, 0);
    chk_byte("R1", 8'h00, 2);
    send_ones(5, 0);
    rst_n = 1'b0;
    #1;
    chk("R1", "byte_vld in reset", int'(byte_vld), 0);
    chk("R1", "byte_data in reset", int'(byte_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_seen = 1'b0;
    send_ones(4, 0);
    send_word(1'b0, 8'h11, 0);
    chk("R1", "ones kept across reset", int'(pulse_seen), 0);
    send_ones(9, 0);
    send_word(1'b0, 8'h22, 0);
    chk_byte("R1", 8'h22, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule